// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns parallel characters into asynchronous frames on a single serial line. Each frame has a low start cell, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop interval of 1, 1.5 or 2 bit cells. An external bit-rate enable supplies the timing. Each bit cell lasts a fixed number of enabled clocks: 1, 16, 32 or 64. With a count of 1 the line is isochronous, so one enable equals one bit cell.

A one-entry holding register sits in front of the shifter. The producer watches `ready` and pulses `loadStb` with a character and an 8-bit mode word. The holding register keeps both. When the shifter finishes a stop interval with the holding register full, the next start cell follows straight away. This lets a stream of characters go out with no idle gap. Every frame uses the mode word that was captured with its own character.

Top module: `asyncTxTop`

## Requirements
- R1: While no frame is in progress the line is high (mark). A frame begins with the line low (space) for one bit cell.
- R2: Mode bits [5:4] set the character length: 00=5, 01=6, 10=7, 11=8 bits. The data bits are sent least significant first. Character bits at or above the selected length have no effect on the line.
- R3: Mode bit 0 set adds a parity bit directly after the last data bit. Mode bit 1 set selects even parity, so the data bits plus the parity bit carry an even count of ones. Mode bit 1 clear selects odd parity.
- R4: Mode bits [3:2] select the stop interval, held high: 00 = 1 cell, 01 = 1.5 cells (1.5 × the multiplier in enabled clocks), 10 or 11 = 2 cells.
- R5: Mode bits [7:6] select the enabled clocks per bit cell: 00 = 1 (isochronous), 01 = 16, 10 = 32, 11 = 64. The line, `busy` and the frame progress change only after a clock edge at which `bitClkEn` is high.
- R6: In the isochronous setting (bits [7:6] = 00), a stop selection of 1.5 gives a stop interval of one cell.
- R7: A load is accepted only while `ready` is high. `ready` then goes low on the next cycle. A load while `ready` is low is ignored and leaves the held character and mode unchanged.
- R8: If a character is held when a stop interval ends, its start cell begins on the very next enabled clock, with no idle cell in between.
- R9: `busy` rises with the start cell and falls when the stop interval ends and no character is held.
- R10: While reset is asserted the line is high, `busy` is low and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClkEn | input | 1 | Bit-rate enable, one pulse per multiplier clock |
| txChar | input | 8 | Character to send, LSB first |
| loadStb | input | 1 | One-cycle load request for `txChar` and `modeReg` |
| modeReg | input | 8 | Frame mode: [7:6] clocks per bit, [5:4] length, [3:2] stop, [1] even, [0] parity enable |
| txLine | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is being shifted out |
| ready | output | 1 | Holding register is empty and can take a load |

## Verification
Assertions check the cycle-level rules on every cycle. The line is high whenever `busy` is low. `busy` rises only together with a low line. The line and the frame state stay put on clocks without an enable. An accepted load drops `ready` at once, and a held character stays unchanged until the shifter takes it. The bench's scenarios are the only way to show the frame contents and lengths: bit order, masking of unused upper bits, the parity value for each polarity, the 1.5-cell stop under each multiplier, and the seamless join of back-to-back frames. A behavioural frame model checks these against the line cycle by cycle, with the enable both steady and irregular.

// File: rtl/asyncTxPkg.sv
package asyncTxPkg;

  localparam int MODE_W = 8;
  localparam int CHAR_W = 8;
  localparam int MAX_MULT = 64;
  localparam int CNT_W = $clog2(2 * MAX_MULT) + 1;
  localparam int IDX_W = $clog2(CHAR_W);

  // mode field positions (decoded by both control and datapath)
  localparam int PAR_EN_BIT = 0;
  localparam int PAR_EVEN_BIT = 1;
  localparam int STOP_LO = 2;
  localparam int LEN_LO = 4;
  localparam int MULT_LO = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic takeHold;
    logic nextData;
    logic putParity;
    logic putStop;
    logic goIdle;
  } txStrobe_t;

  function automatic int unsigned multOf(input logic [MODE_W-1:0] mode);
    case (mode[MULT_LO+:2])
      2'b00:   return 1;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int unsigned charLenOf(input logic [MODE_W-1:0] mode);
    return 5 + int'(mode[LEN_LO+:2]);
  endfunction

  function automatic int unsigned stopTicksOf(input logic [MODE_W-1:0] mode);
    int unsigned m;
    m = multOf(mode);
    case (mode[STOP_LO+:2])
      2'b00:   return m;
      2'b01:   return (m == 1) ? 1 : m + m / 2;
      default: return 2 * m;
    endcase
  endfunction

endpackage

// File: rtl/asyncTxCtrl.sv
module asyncTxCtrl
  import asyncTxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClkEn,
  input  logic              holdValid,
  input  logic [MODE_W-1:0] holdMode,
  output txStrobe_t         strobes,
  output logic              busy
);

  txState_t          state, stateNext;
  logic [CNT_W-1:0]  cellCnt, cellCntNext;
  logic [IDX_W-1:0]  bitIdx, bitIdxNext;
  logic [MODE_W-1:0] actMode, actModeNext;
  logic              lastCell, lastStop, lastBit;

  assign lastCell = (cellCnt == CNT_W'(multOf(actMode) - 1));
  assign lastStop = (cellCnt == CNT_W'(stopTicksOf(actMode) - 1));
  assign lastBit  = (bitIdx == IDX_W'(charLenOf(actMode) - 1));

  always_comb begin
    strobes     = '0;
    stateNext   = state;
    cellCntNext = cellCnt;
    bitIdxNext  = bitIdx;
    actModeNext = actMode;
    if (bitClkEn) begin
      cellCntNext = cellCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          cellCntNext = '0;
          if (holdValid) begin
            strobes.takeHold = 1'b1;
            actModeNext      = holdMode;
            stateNext        = ST_START;
          end
        end
        ST_START: begin
          if (lastCell) begin
            strobes.nextData = 1'b1;
            cellCntNext      = '0;
            bitIdxNext       = '0;
            stateNext        = ST_DATA;
          end
        end
        ST_DATA: begin
          if (lastCell) begin
            cellCntNext = '0;
            if (!lastBit) begin
              strobes.nextData = 1'b1;
              bitIdxNext       = bitIdx + 1'b1;
            end else if (actMode[PAR_EN_BIT]) begin
              strobes.putParity = 1'b1;
              stateNext         = ST_PARITY;
            end else begin
              strobes.putStop = 1'b1;
              stateNext       = ST_STOP;
            end
          end
        end
        ST_PARITY: begin
          if (lastCell) begin
            strobes.putStop = 1'b1;
            cellCntNext     = '0;
            stateNext       = ST_STOP;
          end
        end
        ST_STOP: begin
          if (lastStop) begin
            cellCntNext = '0;
            if (holdValid) begin
              strobes.takeHold = 1'b1;
              actModeNext      = holdMode;
              stateNext        = ST_START;
            end else begin
              strobes.goIdle = 1'b1;
              stateNext      = ST_IDLE;
            end
          end
        end
        default: begin
          strobes.goIdle = 1'b1;
          cellCntNext    = '0;
          stateNext      = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cellCnt <= '0;
      bitIdx  <= '0;
      actMode <= '0;
    end else begin
      state   <= stateNext;
      cellCnt <= cellCntNext;
      bitIdx  <= bitIdxNext;
      actMode <= actModeNext;
    end
  end

  assign busy = (state != ST_IDLE);

  // R5
  tick_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitClkEn |=> ($stable(state) && $stable(cellCnt) && $stable(bitIdx)));

endmodule

// File: rtl/asyncTxDatapath.sv
module asyncTxDatapath
  import asyncTxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] txChar,
  input  logic              loadStb,
  input  logic [MODE_W-1:0] modeReg,
  input  txStrobe_t         strobes,
  output logic              holdValid,
  output logic [MODE_W-1:0] holdMode,
  output logic              txLine,
  output logic              ready
);

  logic [CHAR_W-1:0] holdChar;
  logic [CHAR_W-1:0] shiftReg;
  logic [CHAR_W-1:0] lenMask;
  logic [CHAR_W-1:0] maskedChar;
  logic              parityBit;
  logic              onesOdd;

  // mask off bits beyond the selected character length
  for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
    assign lenMask[i] = (i < int'(charLenOf(holdMode)));
  end

  assign maskedChar = holdChar & lenMask;
  assign onesOdd    = ^maskedChar;
  assign ready      = !holdValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdChar  <= '0;
      holdMode  <= '0;
    end else if (strobes.takeHold) begin
      holdValid <= 1'b0;
    end else if (loadStb && !holdValid) begin
      holdValid <= 1'b1;
      holdChar  <= txChar;
      holdMode  <= modeReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
      txLine    <= 1'b1;
    end else begin
      if (strobes.takeHold) begin
        shiftReg  <= maskedChar;
        parityBit <= holdMode[PAR_EVEN_BIT] ? onesOdd : !onesOdd;
        txLine    <= 1'b0;
      end else if (strobes.nextData) begin
        shiftReg <= shiftReg >> 1;
        txLine   <= shiftReg[0];
      end else if (strobes.putParity) begin
        txLine <= parityBit;
      end else if (strobes.putStop || strobes.goIdle) begin
        txLine <= 1'b1;
      end
    end
  end

  // R7
  load_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && ready) |=> !ready);

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && !strobes.takeHold) |=> (holdValid && $stable(holdChar) && $stable(holdMode)));

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeHold |=> !txLine);

endmodule

// File: rtl/asyncTxTop.sv
module asyncTxTop
  import asyncTxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClkEn,
  input  logic [7:0] txChar,
  input  logic       loadStb,
  input  logic [7:0] modeReg,
  output logic       txLine,
  output logic       busy,
  output logic       ready
);

  txStrobe_t         strobes;
  logic              holdValid;
  logic [MODE_W-1:0] holdMode;

  asyncTxCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitClkEn  (bitClkEn),
    .holdValid (holdValid),
    .holdMode  (holdMode),
    .strobes   (strobes),
    .busy      (busy)
  );

  asyncTxDatapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .txChar    (txChar),
    .loadStb   (loadStb),
    .modeReg   (modeReg),
    .strobes   (strobes),
    .holdValid (holdValid),
    .holdMode  (holdMode),
    .txLine    (txLine),
    .ready     (ready)
  );

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine);

  // R5
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitClkEn |=> ($stable(txLine) && $stable(busy)));

endmodule

// File: tb/test_asyncTxTop.sv
module test_asyncTxTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitClkEn = 1'b1;
  logic [7:0] txChar = '0;
  logic       loadStb = 1'b0;
  logic [7:0] modeReg = '0;
  logic       txLine, busy, ready;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  bit gappy = 0;
  bit modelLive = 0;
  logic [7:0] lfsr = 8'hA5;

  // reference model state
  bit         mq[$];
  bit         mLine = 1, mBusy = 0, mHold = 0, mReadyBefore;
  logic [7:0] mHoldChar, mHoldMode;

  always #2 clk = ~clk;

  asyncTxTop i_asyncTxTop (
    .clk(clk), .rstN(rstN), .bitClkEn(bitClkEn), .txChar(txChar),
    .loadStb(loadStb), .modeReg(modeReg), .txLine(txLine), .busy(busy), .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // frame expansion: every cell repeated per enabled clock
  task automatic pushCell(input bit v, input int n);
    for (int k = 0; k < n; k++) mq.push_back(v);
  endtask

  task automatic buildFrame(input logic [7:0] ch, input logic [7:0] md);
    int mult, len, stopN, ones;
    case (md[7:6]) 2'b00: mult = 1; 2'b01: mult = 16; 2'b10: mult = 32; default: mult = 64; endcase
    len = 5 + md[5:4];
    case (md[3:2])
      2'b00: stopN = mult;
      2'b01: stopN = (mult == 1) ? 1 : (mult * 3) / 2;
      default: stopN = 2 * mult;
    endcase
    ones = 0;
    pushCell(1'b0, mult);
    for (int b = 0; b < len; b++) begin
      pushCell(ch[b], mult);
      ones += ch[b];
    end
    if (md[0]) pushCell(md[1] ? (ones % 2 == 1) : (ones % 2 == 0), mult);
    pushCell(1'b1, stopN);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete();
      mLine = 1; mBusy = 0; mHold = 0;
    end else begin
      mReadyBefore = !mHold;
      if (bitClkEn) begin
        if (mq.size() == 0) begin
          if (mHold) begin
            buildFrame(mHoldChar, mHoldMode);
            mHold = 0; mBusy = 1;
            mLine = mq.pop_front();
          end else begin
            mBusy = 0; mLine = 1;
          end
        end else begin
          mLine = mq.pop_front();
        end
      end
      if (loadStb && mReadyBefore) begin
        mHold = 1; mHoldChar = txChar; mHoldMode = modeReg;
      end
    end
    modelLive = 1;
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (modelLive && !finished) begin
      check(txLine === mLine, "R1 R2 R3 R4 R5 R6 R8 line", txLine, mLine);
      check(busy === mBusy, "R9 busy", busy, mBusy);
      check(ready === !mHold, "R7 ready", ready, !mHold);
    end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bitClkEn <= gappy ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  task automatic sendChar(input logic [7:0] ch, input logic [7:0] md);
    @(negedge clk);
    while (!ready) @(negedge clk);
    txChar = ch; modeReg = md; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || !ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(txLine === 1'b1, "R10 line in reset", txLine, 1);
    check(busy === 1'b0, "R10 busy in reset", busy, 0);
    check(ready === 1'b1, "R10 ready in reset", ready, 1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(txLine === 1'b1, "R1 idle mark", txLine, 1);

    // R2 R3 known frame, x1, 8 bits, even parity, 1 stop
    begin
      bit exp[11] = '{0, 1,0,1,0,1,1,0,0, 0, 1};
      sendChar(8'h35, 8'h33);
      while (txLine) @(negedge clk);
      for (int k = 0; k < 11; k++) begin
        check(txLine === exp[k], "R2 R3 x1 known frame", txLine, exp[k]);
        @(negedge clk);
      end
    end
    waitIdle();

    // R6 R2 x1, 5 bits, odd parity, 1.5 stop -> 1 cell; upper bits ignored
    sendChar(8'hE5, 8'h05);
    sendChar(8'h1A, 8'h05);
    waitIdle();

    // R4 R8 x16, 7 bits, no parity, 1.5 stop, back to back
    sendChar(8'h7F, 8'h64);
    sendChar(8'h00, 8'h64);
    sendChar(8'h55, 8'h64);
    waitIdle();

    // R5 x32, 6 bits, even parity, 2 stop, irregular enable
    gappy = 1;
    sendChar(8'hC9, 8'h9B);
    sendChar(8'h3F, 8'h9B);
    waitIdle();

    // R7 x64, 8 bits, odd parity, 2 stop; a load while not ready is ignored
    sendChar(8'hA3, 8'hFD);
    sendChar(8'h5C, 8'hFD);
    @(negedge clk);
    check(ready === 1'b0, "R7 ready low with held char", ready, 0);
    txChar = 8'hFF; modeReg = 8'h00; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    check(ready === 1'b0, "R7 ignored load keeps ready low", ready, 0);
    waitIdle();

    // R4 x16, 8 bits, even parity, 1 stop, mixed with 2-stop frame
    sendChar(8'h81, 8'h73);
    sendChar(8'h18, 8'h7B);
    waitIdle();
    gappy = 0;
    check(txLine === 1'b1, "R1 idle after run", txLine, 1);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testCnt++; failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule